// File: doc/BRIEF.md
# Line-Interleaved Imager Exposure Sequencer

This block drives the integrate/readout control of a linear light sensor so that exposures line up with the raster of a video projector. It runs in the sensor clock domain and takes raw horizontal and vertical sync from the projector. Every transition of horizontal sync, rising or falling, counts as one half-line. A rising edge of vertical sync opens a new projected frame. While `start_o` is high the sensor integrates. When `start_o` drops, the sensor shifts its pixels out.

In slow capture the sensor integrates for the whole projected frame, and each projected frame is one output frame. In fast capture the sensor integrates for one projected line and then spends two lines on readout, so one line in three is captured. The captured line set moves by one line on each projected frame. After five projected frames every line has been seen, and those frames together make one composite output frame. The block reports the line and frame within the composite that the current exposure belongs to. It pulses `composite_done_o` when a composite completes.

`enable_in` and `fast_mode_in` are taken as synchronous to `clk`. The capture mode is sampled only at vertical sync.

Top module: `imager_expo_seq`

## Requirements
- R1: After reset, and at all times while `enable_in` is low, `start_o` and `frame_valid_o` are 0, `tag_line_o` and `tag_frame_o` are 0, and horizontal sync edges do not change `tag_line_o`.
- R2: Both the rising and the falling transitions of `hsync_in` each count as one half-line. `tag_line_o` equals the number of whole lines (half-lines / 2) since the last vertical sync, and it saturates at its maximum.
- R3: A rising edge of `vsync_in` returns `tag_line_o` to 0 and opens a new projected frame. A falling edge of `vsync_in` has no effect.
- R4: In slow capture (`fast_mode_in` = 0), `start_o` stays high for every half-line of each projected frame, continuously across vertical sync.
- R5: In fast capture (`fast_mode_in` = 1), `start_o` is high for exactly one line, then low for the next two lines, and the pattern repeats.
- R6: In fast capture, projected frame index f of a composite exposes lines L (counted from 0) with L mod 3 = f mod 3. Frame 0 exposes lines 0,3,6; frame 1 exposes 1,4,7; frame 2 exposes 2,5,8.
- R7: `tag_frame_o` counts the projected frames of a composite: 0..FRAMES_PER_COMP-1 (default 5) in fast capture, and always 0 in slow capture. `composite_done_o` is a one-cycle pulse at the vertical sync that ends the last frame of a composite.
- R8: A change of `fast_mode_in` takes effect only at the next vertical sync. That sync restarts the composite at frame 0 and gives no `composite_done_o` pulse for the composite that was cut short.
- R9: Dropping `enable_in` forces `start_o` low by the next clock edge. After `enable_in` returns, nothing is exposed and `frame_valid_o` stays 0 until the next vertical sync, which starts at frame 0 and line 0.
- R10: `start_o` is a register in the `clk` domain. It reflects a sync transition no later than the fourth clock edge after the sync input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor clock (10 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| enable_in | input | 1 | Sequencer enable; low clears all state |
| fast_mode_in | input | 1 | 1 = fast interleaved capture, 0 = slow full-frame capture |
| hsync_in | input | 1 | Projector horizontal sync, asynchronous |
| vsync_in | input | 1 | Projector vertical sync, asynchronous |
| start_o | output | 1 | Sensor integrate (high) / readout (low) |
| frame_valid_o | output | 1 | High while a sequence is running |
| tag_line_o | output | LINE_W | Current projected line since vertical sync |
| tag_frame_o | output | FRAME_W | Projected frame index within the composite |
| composite_done_o | output | 1 | One-cycle pulse when a composite completes |

## Verification
The bench walks six fast-capture projected frames. It checks the expected exposure line of every half-line, so a phase that fails to advance, that advances by the wrong amount, or that does not wrap after frame four shows up as start high on the wrong lines. A design that counts only one horizontal sync edge would report a line tag of half the expected value and would expose for two lines instead of one.

Directed tests then cover the remaining rules:
- a mode flip in the middle of a frame, which a design that samples the mode early would act on at once;
- the completion pulse, which would be doubled or missing if it were tied to the wrong frame;
- a disable followed by a re-enable, where a design that forgets to clear its state would restart exposure before the next vertical sync.

// File: rtl/imgseq_pkg.sv
package imgseq_pkg;

    typedef enum logic {
        MODE_SLOW = 1'b0,
        MODE_FAST = 1'b1
    } cap_mode_e;

    localparam int unsigned PHASE_COUNT = 3;

    typedef struct packed {
        logic      running;
        cap_mode_e mode;
        logic [1:0] phase;
    } seq_state_t;

    function automatic logic [1:0] mod3_next(input logic [1:0] v);
        return (v == 2'd2) ? 2'd0 : v + 2'd1;
    endfunction

endpackage

// File: rtl/seq_sync_edge.sv
module seq_sync_edge #(
    parameter bit BOTH_EDGES = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic pulse_o
);
    logic [2:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[1:0], async_in};
    end

    generate
        if (BOTH_EDGES) begin : g_any_edge
            assign pulse_o = pipe_q[1] ^ pipe_q[2];
        end else begin : g_rise_edge
            assign pulse_o = pipe_q[1] & ~pipe_q[2];
        end
    endgenerate

    a_r10_pulse_single: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/seq_line_track.sv
module seq_line_track #(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              hs_pulse,
    output logic [LINE_W-1:0] line_o,
    output logic [1:0]        mod3_o
);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic              half_q;
    logic [LINE_W-1:0] line_q;
    logic [1:0]        mod3_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            half_q <= 1'b0;
            line_q <= '0;
            mod3_q <= 2'd0;
        end else if (hs_pulse) begin
            half_q <= ~half_q;
            if (half_q) begin
                mod3_q <= imgseq_pkg::mod3_next(mod3_q);
                if (line_q != LINE_MAX) line_q <= line_q + 1'b1;
            end
        end
    end

    assign line_o = line_q;
    assign mod3_o = mod3_q;

    a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clear |=> (line_o == '0) && (mod3_o == 2'd0));

    a_r2_never_back: assert property (@(posedge clk) disable iff (rst)
        !clear |=> line_o >= $past(line_o));

    a_r2_one_line_per_two: assert property (@(posedge clk) disable iff (rst)
        (!clear && !hs_pulse) |=> $stable(line_o));

endmodule

// File: rtl/seq_frame_ctrl.sv
module seq_frame_ctrl
    import imgseq_pkg::*;
#(
    parameter int FRAMES  = 5,
    parameter int FRAME_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               fast_req,
    input  logic               vs_pulse,
    output seq_state_t         state_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               done_o
);
    localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(FRAMES - 1);

    seq_state_t         st_q;
    logic [FRAME_W-1:0] frame_q;
    logic               done_q;
    cap_mode_e          req_mode;
    logic               at_last;

    assign req_mode = fast_req ? MODE_FAST : MODE_SLOW;
    assign at_last  = (st_q.mode == MODE_SLOW) || (frame_q == LAST_FRAME);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '{running: 1'b0, mode: MODE_SLOW, phase: 2'd0};
            frame_q <= '0;
            done_q  <= 1'b0;
        end else if (!enable) begin
            st_q.running <= 1'b0;
            st_q.phase   <= 2'd0;
            frame_q      <= '0;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (vs_pulse) begin
                st_q.running <= 1'b1;
                st_q.mode    <= req_mode;
                if (!st_q.running) begin
                    st_q.phase <= 2'd0;
                    frame_q    <= '0;
                end else begin
                    done_q <= at_last;
                    if (at_last || (req_mode != st_q.mode)) begin
                        st_q.phase <= 2'd0;
                        frame_q    <= '0;
                    end else begin
                        st_q.phase <= mod3_next(st_q.phase);
                        frame_q    <= frame_q + 1'b1;
                    end
                end
            end
        end
    end

    assign state_o = st_q;
    assign frame_o = frame_q;
    assign done_o  = done_q;

    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r7_done_at_vsync: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(vs_pulse));

    a_r8_mode_only_at_vsync: assert property (@(posedge clk) disable iff (rst)
        !vs_pulse |=> $stable(state_o.mode));

    a_r7_slow_frame_zero: assert property (@(posedge clk) disable iff (rst)
        (state_o.mode == MODE_SLOW) |-> (frame_o == '0));

endmodule

// File: rtl/imager_expo_seq.sv
module imager_expo_seq
    import imgseq_pkg::*;
#(
    parameter int LINE_W          = 11,
    parameter int FRAMES_PER_COMP = 5,
    parameter int FRAME_W         = (FRAMES_PER_COMP > 1) ? $clog2(FRAMES_PER_COMP) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable_in,
    input  logic               fast_mode_in,
    input  logic               hsync_in,
    input  logic               vsync_in,
    output logic               start_o,
    output logic               frame_valid_o,
    output logic [LINE_W-1:0]  tag_line_o,
    output logic [FRAME_W-1:0] tag_frame_o,
    output logic               composite_done_o
);
    logic               hs_pulse;
    logic               vs_pulse;
    logic [LINE_W-1:0]  line_cnt;
    logic [1:0]         line_mod3;
    seq_state_t         seq_st;
    logic [FRAME_W-1:0] frame_idx;
    logic               expose_d;
    logic               start_q;

    seq_sync_edge #(.BOTH_EDGES(1'b1)) u_hsync (
        .clk(clk), .rst(rst), .async_in(hsync_in), .pulse_o(hs_pulse)
    );

    seq_sync_edge #(.BOTH_EDGES(1'b0)) u_vsync (
        .clk(clk), .rst(rst), .async_in(vsync_in), .pulse_o(vs_pulse)
    );

    seq_line_track #(.LINE_W(LINE_W)) u_lines (
        .clk(clk), .rst(rst),
        .clear(vs_pulse || !enable_in),
        .hs_pulse(hs_pulse),
        .line_o(line_cnt),
        .mod3_o(line_mod3)
    );

    seq_frame_ctrl #(.FRAMES(FRAMES_PER_COMP), .FRAME_W(FRAME_W)) u_frames (
        .clk(clk), .rst(rst),
        .enable(enable_in),
        .fast_req(fast_mode_in),
        .vs_pulse(vs_pulse),
        .state_o(seq_st),
        .frame_o(frame_idx),
        .done_o(composite_done_o)
    );

    assign expose_d = seq_st.running &&
                      ((seq_st.mode == MODE_SLOW) || (line_mod3 == seq_st.phase));

    always_ff @(posedge clk) begin
        if (rst) start_q <= 1'b0;
        else     start_q <= enable_in && expose_d;
    end

    assign start_o       = start_q;
    assign frame_valid_o = seq_st.running;
    assign tag_line_o    = line_cnt;
    assign tag_frame_o   = frame_idx;

    a_r9_disable_forces_low: assert property (@(posedge clk) disable iff (rst)
        !enable_in |=> !start_o && !frame_valid_o);

    a_r1_start_needs_valid: assert property (@(posedge clk) disable iff (rst)
        start_o |-> $past(frame_valid_o));

    a_r4_slow_holds_high: assert property (@(posedge clk) disable iff (rst)
        (enable_in && seq_st.running && seq_st.mode == MODE_SLOW) |=> start_o);

endmodule

// File: tb/imager_expo_seq_tb_top.sv
module imager_expo_seq_tb_top;
    localparam int CLK_NS  = 100;
    localparam int LINE_W  = 11;
    localparam int FRAME_W = 3;

    // {done expected, frame index[2:0], start pattern per line 0..8}
    localparam logic [12:0] VEC [6] = '{
        {1'b0, 3'd0, 9'b001001001},
        {1'b0, 3'd1, 9'b010010010},
        {1'b0, 3'd2, 9'b100100100},
        {1'b0, 3'd3, 9'b001001001},
        {1'b0, 3'd4, 9'b010010010},
        {1'b1, 3'd0, 9'b001001001}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable_in = 1'b0;
    logic fast_mode_in = 1'b0;
    logic hsync_in = 1'b0;
    logic vsync_in = 1'b0;
    logic start_o, frame_valid_o, composite_done_o;
    logic [LINE_W-1:0]  tag_line_o;
    logic [FRAME_W-1:0] tag_frame_o;

    int n_tests = 0;
    int n_fail  = 0;
    int done_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    imager_expo_seq #(.LINE_W(LINE_W), .FRAMES_PER_COMP(5)) dut_i (
        .clk(clk), .rst(rst),
        .enable_in(enable_in), .fast_mode_in(fast_mode_in),
        .hsync_in(hsync_in), .vsync_in(vsync_in),
        .start_o(start_o), .frame_valid_o(frame_valid_o),
        .tag_line_o(tag_line_o), .tag_frame_o(tag_frame_o),
        .composite_done_o(composite_done_o)
    );

    always @(negedge clk) if (!rst && composite_done_o) done_cnt++;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // R10: one sync transition, output sampled four clock edges later
    task automatic hs_edge();
        @(negedge clk);
        hsync_in = ~hsync_in;
        repeat (4) @(negedge clk);
    endtask

    task automatic vs_cycle();
        @(negedge clk);
        vsync_in = 1'b1;
        repeat (4) @(negedge clk);
        vsync_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int d0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "start after reset", int'(start_o), 0);
        check("R1", "valid after reset", int'(frame_valid_o), 0);
        check("R1", "line after reset", int'(tag_line_o), 0);
        check("R1", "frame after reset", int'(tag_frame_o), 0);

        // R9 enabled but no vertical sync yet
        enable_in = 1'b1;
        fast_mode_in = 1'b1;
        hs_edge(); hs_edge();
        check("R9", "start before vsync", int'(start_o), 0);
        check("R9", "valid before vsync", int'(frame_valid_o), 0);

        // Table walk: fast capture over six projected frames (R2 R3 R5 R6 R7 R10)
        for (int v = 0; v < 6; v++) begin
            d0 = done_cnt;
            vs_cycle();
            check("R7", "done pulses at vsync", done_cnt - d0, int'(VEC[v][12]));
            check("R7", "frame index", int'(tag_frame_o), int'(VEC[v][11:9]));
            check("R3", "line after vsync", int'(tag_line_o), 0);
            for (int ln = 0; ln < 9; ln++) begin
                check("R6", "start at line head", int'(start_o), int'(VEC[v][ln]));
                check("R2", "line tag", int'(tag_line_o), ln);
                hs_edge();
                check("R5", "start at half line", int'(start_o), int'(VEC[v][ln]));
                check("R2", "line tag half", int'(tag_line_o), ln);
                hs_edge();
            end
            check("R10", "start at line 9", int'(start_o), int'(VEC[v][0]));
        end

        // R8: mode change mid-frame is deferred (line 10 not exposed in frame 0)
        fast_mode_in = 1'b0;
        hs_edge(); hs_edge();
        check("R8", "fast pattern kept", int'(start_o), 0);
        d0 = done_cnt;
        vs_cycle();
        check("R8", "no done on cut composite", done_cnt - d0, 0);
        check("R8", "frame restart", int'(tag_frame_o), 0);
        for (int ln = 0; ln < 4; ln++) begin
            check("R4", "slow start high", int'(start_o), 1);
            hs_edge();
            check("R4", "slow start half", int'(start_o), 1);
            hs_edge();
        end
        d0 = done_cnt;
        vs_cycle();
        check("R7", "slow done each frame", done_cnt - d0, 1);
        check("R7", "slow frame index", int'(tag_frame_o), 0);
        check("R4", "slow across vsync", int'(start_o), 1);

        // R3: falling vertical sync alone does nothing
        hs_edge(); hs_edge();
        check("R3", "line before fall", int'(tag_line_o), 1);

        // R9 / R1: disable clears and ignores sync
        @(negedge clk);
        enable_in = 1'b0;
        @(negedge clk);
        check("R9", "start drops", int'(start_o), 0);
        check("R9", "valid drops", int'(frame_valid_o), 0);
        hs_edge(); hs_edge(); hs_edge(); hs_edge();
        check("R1", "line ignored when off", int'(tag_line_o), 0);
        check("R1", "frame zero when off", int'(tag_frame_o), 0);

        enable_in = 1'b1;
        fast_mode_in = 1'b1;
        hs_edge(); hs_edge();
        check("R9", "no exposure until vsync", int'(start_o), 0);
        check("R9", "no valid until vsync", int'(frame_valid_o), 0);
        d0 = done_cnt;
        vs_cycle();
        check("R9", "restart frame 0", int'(tag_frame_o), 0);
        check("R9", "restart valid", int'(frame_valid_o), 1);
        check("R9", "restart exposure", int'(start_o), 1);
        check("R9", "no done at restart", done_cnt - d0, 0);
        hs_edge(); hs_edge();
        check("R5", "line 1 readout", int'(start_o), 0);

        report();
    end

endmodule